// File: doc/BRIEF.md
# Frequency Input Pulse Conditioner

The block takes an asynchronous frequency input of any duty cycle and turns each of its rising edges into one well-formed, active-low pulse for a clocked frequency-to-voltage converter. The pulse is exactly one converter-clock period long. It begins on a rising clock edge and ends on the next rising edge, so exactly one falling clock edge lies at its centre, with half a period of margin on each side. For the required 200 ns margins, the clock period must be at least 400 ns. An active-high complement is driven from the same flop so that a differential comparator can be driven.

The input passes through a synchronizer and then a rising-edge detector. A slot controller launches the pulses. After every pulse, the controller enforces a rest of at least `REST_CYC` high cycles. An edge that arrives while the controller is busy is held in a one-deep slot and issued at the first free slot. A further edge that arrives while one is already held is dropped and raises a sticky overrun flag. With the defaults, edges spaced three or more clock cycles apart are never held. A 100 kHz input therefore needs a clock of at least 300 kHz.

Top module: `fpc_pulse_cond`

## Requirements
- R1: While rst_ni is low, pls_n_o is 1, pls_o is 0 and overrun_o is 0. Reset also discards any held edge, so after reset no pulse appears until a new rising edge of freq_i.
- R2: When rising edges of freq_i are at least REST_CYC+1 clock cycles apart, each rising edge produces exactly one pulse, whatever the high and low times.
- R3: A pulse (pls_n_o = 0) lasts exactly one clock period. It starts and ends on rising clock edges, so pls_n_o is never low across two falling clock edges.
- R4: pls_o is always the inverse of pls_n_o.
- R5: If freq_i is first captured high at rising clock edge k, and no pulse or rest is pending, pls_n_o is low from edge k+SYNC_STAGES to edge k+SYNC_STAGES+1. With the defaults, it is low from edge k+2 to edge k+3.
- R6: Between two pulses, pls_n_o stays high for at least REST_CYC clock periods.
- R7: A rising edge that arrives during a pulse or its rest is held (depth one) and its pulse is issued at the first free slot. With the defaults, two rising edges two cycles apart give two pulses whose starts are three cycles apart.
- R8: A rising edge that arrives while the block is busy and another edge is already held is dropped. It sets overrun_o, which stays 1 until reset. With the defaults, five rising edges two cycles apart give four pulses and overrun_o = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Converter clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| freq_i | input | 1 | Asynchronous frequency input |
| pls_n_o | output | 1 | Conditioned pulse, active low |
| pls_o | output | 1 | Complement of pls_n_o |
| overrun_o | output | 1 | Sticky flag: an edge was dropped |

## Verification
The assertions check the following on every cycle: the one-cycle pulse width, the complement relation, the silence during the rest interval, the service of a held edge at the first free slot, the launch that follows a free edge, and the stickiness of the overrun flag. Only the bench scenarios can show the end-to-end behaviour at the ports. That includes the exact sample in which each pulse appears after an input edge, across a sweep of high and low widths. It also includes the count of pulses against input edges, the queued and dropped edges in fast bursts, and the discarding of a held edge by reset.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  localparam int unsigned SYNC_STAGES_DEF = 2;
  localparam int unsigned REST_CYC_DEF    = 2;

  typedef struct packed {
    logic active;
    logic pend;
    logic ovr;
  } slot_t;
endpackage

// File: rtl/fpc_sync.sv
module fpc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q[0] <= 1'b0;
        else         ff_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q[g] <= 1'b0;
        else         ff_q[g] <= ff_q[g-1];
      end
    end
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/fpc_edge.sv
module fpc_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;

  // R2: a level rise yields a single-cycle strobe
  p_rise_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/fpc_slot.sv
module fpc_slot
  import fpc_pkg::*;
#(
  parameter int unsigned REST_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rise_i,
  output logic active_o,
  output logic ovr_o
);
  localparam int unsigned RW = (REST_CYC > 1) ? $clog2(REST_CYC) : 1;
  localparam logic [RW-1:0] REST_LOAD = RW'(REST_CYC - 1);

  slot_t        st_q, st_d;
  logic [RW-1:0] rest_q, rest_d;
  logic          busy, launch;

  always_comb begin
    busy   = st_q.active | (rest_q != '0);
    launch = (rise_i | st_q.pend) & ~busy;
    st_d.active = launch;
    // busy: store the edge; free: a held edge is served, a new one takes its place
    st_d.pend = busy ? (st_q.pend | rise_i) : (st_q.pend & rise_i);
    st_d.ovr  = st_q.ovr | (busy & st_q.pend & rise_i);
    if (st_q.active)        rest_d = REST_LOAD;
    else if (rest_q != '0)  rest_d = rest_q - 1'b1;
    else                    rest_d = rest_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= '0;
      rest_q <= '0;
    end else begin
      st_q   <= st_d;
      rest_q <= rest_d;
    end
  end

  assign active_o = st_q.active;
  assign ovr_o    = st_q.ovr;

  p_one_period_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q.active |=> !st_q.active);

  p_launch_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_i && !busy) |=> st_q.active);

  p_rest_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rest_q != '0) |=> !st_q.active);

  p_held_served_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q.pend && !busy) |=> st_q.active);

  p_ovr_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q.ovr |=> st_q.ovr);
endmodule

// File: rtl/fpc_pulse_cond.sv
module fpc_pulse_cond
  import fpc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF,
  parameter int unsigned REST_CYC    = REST_CYC_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic freq_i,
  output logic pls_n_o,
  output logic pls_o,
  output logic overrun_o
);
  logic lvl, rise, active, ovr;

  fpc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(freq_i), .q_o(lvl)
  );

  fpc_edge u_edge (
    .clk_i (clk_i), .rst_ni(rst_ni), .lvl_i(lvl), .rise_o(rise)
  );

  fpc_slot #(.REST_CYC(REST_CYC)) u_slot (
    .clk_i (clk_i), .rst_ni(rst_ni), .rise_i(rise),
    .active_o(active), .ovr_o(ovr)
  );

  // both outputs come from one flop, so they switch together
  assign pls_n_o   = ~active;
  assign pls_o     = active;
  assign overrun_o = ovr;

  p_cmpl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pls_o != pls_n_o);

  p_rst_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (pls_n_o && !overrun_o));
endmodule

// File: tb/sim_fpc_pulse_cond.sv
`timescale 1ns/1ps
module sim_fpc_pulse_cond;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic freq_i = 1'b0;
  logic pls_n_o, pls_o, overrun_o;

  int n_chk = 0;
  int n_err = 0;
  int cmpl_bad = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  fpc_pulse_cond u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .freq_i(freq_i),
    .pls_n_o(pls_n_o), .pls_o(pls_o), .overrun_o(overrun_o)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    freq_i = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  // sample j is taken before drive j; bit j of lowm is the pulse seen at sample j
  task automatic run_pat(input logic [63:0] pat, input int n, output logic [63:0] lowm);
    lowm = '0;
    for (int j = 0; j < n; j++) begin
      @(negedge clk_i);
      lowm[j] = ~pls_n_o;
      if (pls_o !== ~pls_n_o) cmpl_bad++;
      freq_i = pat[j];
    end
  endtask

  initial begin
    logic [63:0] pat, lowm, expm;
    int p;
    // R1: outputs during reset
    #35;
    chk(pls_n_o === 1'b1 && pls_o === 1'b0 && overrun_o === 1'b0, "R1 reset state",
        {61'd0, pls_n_o, pls_o, overrun_o}, 64'h4);
    rst_ni = 1'b1;

    // R2 R3 R5 R6: sweep high/low widths with spacing >= REST_CYC+1
    for (int h = 1; h <= 4; h++) begin
      for (int l = 1; l <= 4; l++) begin
        p = h + l;
        if (p >= 3) begin
          do_reset();
          pat = '0;
          expm = '0;
          for (int j = 0; j < 6 * p; j++) pat[j] = ((j % p) >= l);
          for (int k = 0; k < 6; k++) expm[p * k + l + 3] = 1'b1;
          run_pat(pat, 64, lowm);
          chk(lowm === expm, $sformatf("R2 R3 R5 R6 pulse timing h=%0d l=%0d", h, l), lowm, expm);
          chk(overrun_o === 1'b0, "R2 no overrun at legal rate", {63'd0, overrun_o}, 64'd0);
        end
      end
    end

    // R7: two edges two cycles apart, second held and issued three cycles later
    do_reset();
    run_pat(64'h0A, 32, lowm);
    chk(lowm === 64'h90, "R7 held edge issued at next slot", lowm, 64'h90);
    chk(overrun_o === 1'b0, "R7 single held edge no overrun", {63'd0, overrun_o}, 64'd0);

    // R8: five edges two cycles apart, one dropped
    do_reset();
    run_pat(64'h2AA, 32, lowm);
    chk(lowm === 64'h2490, "R8 fifth edge dropped", lowm, 64'h2490);
    chk(overrun_o === 1'b1, "R8 overrun set", {63'd0, overrun_o}, 64'd1);
    repeat (5) @(negedge clk_i);
    chk(overrun_o === 1'b1, "R8 overrun sticky", {63'd0, overrun_o}, 64'd1);

    // R1: reset discards a held edge
    do_reset();
    run_pat(64'h0A, 7, lowm);
    chk(lowm === 64'h10, "R1 first pulse before reset", lowm, 64'h10);
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk(pls_n_o === 1'b1 && overrun_o === 1'b0, "R1 outputs held in reset",
        {62'd0, pls_n_o, overrun_o}, 64'h2);
    @(negedge clk_i);
    rst_ni = 1'b1;
    run_pat(64'h0, 16, lowm);
    chk(lowm === 64'h0, "R1 held edge cleared by reset", lowm, 64'h0);

    chk(cmpl_bad == 0, "R4 complement output", cmpl_bad, 64'd0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule